// File: doc/BRIEF.md
# 32-bit Add/Subtract and Bitwise Logic Unit

This block is a purely combinational arithmetic logic unit for 32-bit words. One arithmetic path and one logic path feed a final result selector. The arithmetic path uses a single ripple-carry adder for both addition and subtraction. To subtract, every bit of operand B is inverted through an XOR with the subtract control, and the same control bit is fed in as the adder's carry-in. Each adder stage is a full adder made from two half adders.

The logic path produces one of four bitwise functions of A and B, chosen by a 2-bit select. A mode bit picks which path drives the result. The block also reports a carry-out, a signed-overflow flag and a zero flag. It holds no state, so every output follows the present inputs.

Top module: `alu32`

## Requirements
- R1: With `logic_mode_i`=0 and `sub_i`=0, `result_o` equals (A + B) mod 2^32.
- R2: With `logic_mode_i`=0 and `sub_i`=1, `result_o` equals (A − B) mod 2^32, computed as A + ~B + 1.
- R3: In arithmetic mode, `carry_o` is bit 32 of A + (B XOR {32{sub}}) + sub. For an addition this is the unsigned carry. For a subtraction it is 1 exactly when A ≥ B, compared as unsigned values.
- R4: In arithmetic mode, `ovf_o` is 1 exactly when the two's-complement result lies outside the signed 32-bit range. For an addition that happens when both operands share a sign and the result's sign differs. For a subtraction it happens when the operand signs differ and the result's sign differs from A's.
- R5: With `logic_mode_i`=1, `result_o` is the bitwise function of A and B selected by `lsel_i`: 00 = AND, 01 = OR, 10 = NOR, 11 = XOR.
- R6: With `logic_mode_i`=1, `carry_o` and `ovf_o` are 0, and `sub_i` has no effect on any output.
- R7: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0, in either mode.
- R8: With `logic_mode_i`=0, `lsel_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| sub_i | input | 1 | 1 selects subtraction in the arithmetic path |
| lsel_i | input | 2 | Logic function select (00 AND, 01 OR, 10 NOR, 11 XOR) |
| logic_mode_i | input | 1 | 0 routes the arithmetic result, 1 routes the logic result |
| result_o | output | 32 | Selected result word |
| carry_o | output | 1 | Adder carry-out in arithmetic mode, else 0 |
| ovf_o | output | 1 | Signed overflow in arithmetic mode, else 0 |
| zero_o | output | 1 | 1 when the result is all zeros |

## Verification
All four outputs are due in the same cycle as the inputs that produce them, because no register lies between any input and any output. The bench applies each input set on the falling clock edge. It reads the outputs just before the following rising edge, after the full carry ripple has settled. Each set is checked against values the bench works out from integer arithmetic and from the sign rules in the requirements.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic [1:0]   lsel_i,
  input  logic         logic_mode_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         zero_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] bx, hs, hc, sc, sum, lres;
  logic [W:0]   c;

  assign bx   = b_i ^ {W{sub_i}};
  assign c[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    // first half adder
    assign hs[i]  = a_i[i] ^ bx[i];
    assign hc[i]  = a_i[i] & bx[i];
    // second half adder
    assign sum[i] = hs[i] ^ c[i];
    assign sc[i]  = hs[i] & c[i];
    assign c[i+1] = hc[i] | sc[i];
  end

  for (genvar i = 0; i < W; i++) begin : g_lu
    always_comb begin
      case (lsel_i)
        2'b00:   lres[i] = a_i[i] & b_i[i];
        2'b01:   lres[i] = a_i[i] | b_i[i];
        2'b10:   lres[i] = ~(a_i[i] | b_i[i]);
        default: lres[i] = a_i[i] ^ b_i[i];
      endcase
    end
  end

  assign result_o = logic_mode_i ? lres : sum;
  assign carry_o  = ~logic_mode_i & c[W];
  assign ovf_o    = ~logic_mode_i & (c[W] ^ c[MSB]);
  assign zero_o   = ~|result_o;

  logic [W:0] chk_sum;
  assign chk_sum = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};

  always_comb begin
    if (!logic_mode_i) begin
      // R1 R2 R3
      arith_sum_chk: assert ({carry_o, result_o} == chk_sum);
      // R4
      signed_ovf_chk: assert (ovf_o == ((a_i[MSB] == bx[MSB]) && (result_o[MSB] != a_i[MSB])));
    end else begin
      // R6
      logic_flags_chk: assert (!carry_o && !ovf_o);
      // R5
      if (lsel_i == 2'b10)
        nor_disjoint_chk: assert (((result_o & (a_i | b_i)) == '0) && ((result_o | a_i | b_i) == '1));
      // R5
      if (lsel_i == 2'b11)
        xor_inverse_chk: assert ((result_o ^ a_i) == b_i);
    end
    // R7
    zero_flag_chk: assert (!zero_o || (logic_mode_i ? (lsel_i != 2'b10 || (a_i | b_i) == '1) : 1'b1));
  end

endmodule

// File: tb/alu32_tb.sv
module alu32_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic        sub, mode;
  logic [1:0]  sel;
  logic [31:0] res;
  logic        cy, ov, zf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu32 u_dut (.a_i(a), .b_i(b), .sub_i(sub), .lsel_i(sel), .logic_mode_i(mode),
               .result_o(res), .carry_o(cy), .ovf_o(ov), .zero_o(zf));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ta, input logic [31:0] tb, input logic ts,
                       input logic [1:0] tsel, input logic tm, input string req);
    logic [32:0] full;
    logic [31:0] er;
    logic ec, eo;
    @(negedge clk);
    a = ta; b = tb; sub = ts; sel = tsel; mode = tm;
    if (!tm) begin
      full = ts ? ({1'b0, ta} + {1'b0, ~tb} + 33'd1) : ({1'b0, ta} + {1'b0, tb});
      er = full[31:0];
      ec = ts ? (ta >= tb) : full[32];
      eo = ts ? ((ta[31] != tb[31]) && (er[31] != ta[31]))
              : ((ta[31] == tb[31]) && (er[31] != ta[31]));
    end else begin
      case (tsel)
        2'b00:   er = ta & tb;
        2'b01:   er = ta | tb;
        2'b10:   er = ~(ta | tb);
        default: er = ta ^ tb;
      endcase
      ec = 1'b0; eo = 1'b0;
    end
    #2;
    chk(req, "result", res, er);
    chk(req, "carry", {31'd0, cy}, {31'd0, ec});
    chk(req, "ovf", {31'd0, ov}, {31'd0, eo});
    chk("R7", "zero", {31'd0, zf}, {31'd0, er == 32'd0});
  endtask

  task automatic t_idle();
    apply(32'd0, 32'd0, 1'b0, 2'b00, 1'b0, "R1");
    chk("R7", "idle zero", {31'd0, zf}, 32'd1);
  endtask

  task automatic t_add();
    apply(32'd11, 32'd14, 1'b0, 2'b00, 1'b0, "R1");
    apply(32'hFFFF_FFFF, 32'd1, 1'b0, 2'b00, 1'b0, "R3");
    apply(32'h7FFF_FFFF, 32'd1, 1'b0, 2'b00, 1'b0, "R4");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b00, 1'b0, "R4");
    apply(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 2'b00, 1'b0, "R1");
  endtask

  task automatic t_sub();
    apply(32'd3, 32'hFFFF_FFFE, 1'b1, 2'b00, 1'b0, "R2");
    apply(32'd5, 32'd5, 1'b1, 2'b00, 1'b0, "R2");
    apply(32'd4, 32'd9, 1'b1, 2'b00, 1'b0, "R3");
    apply(32'h8000_0000, 32'd1, 1'b1, 2'b00, 1'b0, "R4");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b00, 1'b0, "R4");
  endtask

  task automatic t_logic();
    for (int s = 0; s < 4; s++) begin
      apply(32'hF0F0_A5A5, 32'hFF00_3C3C, 1'b0, s[1:0], 1'b1, "R5");
      apply(32'hF0F0_A5A5, 32'hFF00_3C3C, 1'b1, s[1:0], 1'b1, "R6");
    end
    apply(32'hFFFF_0000, 32'h0000_FFFF, 1'b0, 2'b10, 1'b1, "R5");
    apply(32'h5555_5555, 32'h5555_5555, 1'b1, 2'b11, 1'b1, "R6");
  endtask

  task automatic t_sel_ignored();
    for (int s = 0; s < 4; s++) begin
      apply(32'hDEAD_BEEF, 32'h0101_0101, 1'b0, s[1:0], 1'b0, "R8");
      apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, s[1:0], 1'b0, "R8");
    end
  endtask

  initial begin
    a = '0; b = '0; sub = 0; sel = '0; mode = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_sel_ignored();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule